// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns parallel characters from a host into an asynchronous serial stream on a single output line. A one-character holding register sits in front of the frame shift register. The host can therefore load the next character while the current one is still being sent, and consecutive characters go out back to back.

The host sees two flags. `tx_ready` means the holding register can take a character. `tx_empty` means nothing is waiting and nothing is being sent. The frame format is set by static configuration inputs: 5 to 8 data bits, one of four parity choices or no parity, and one or two stop bits. Each bit lasts a fixed number of pulses on an external baud-tick input.

Single-cycle enable and disable strobes start and stop the transmitter. A disable lets the frame in the shift register finish. It keeps any waiting character in the holding register until the next enable.

Top module: `uart_dbuf_tx`

## Requirements
- R1: Out of reset the transmitter is disabled, `txd` is 1, `tx_ready` is 0 and `tx_empty` is 1.
- R2: Each frame is a 0 start bit, then the data bits least significant first, then the parity bit when one is selected, then the stop bits at 1. Between frames the line rests at 1.
- R3: The number of data bits is 5 + `fmt_bits`, so codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Unused upper bits of `wr_data` are not sent.
- R4: `fmt_par` selects the parity bit. Code 0 gives no parity bit. Code 1 gives even parity, so the data ones plus the parity bit make an even count. Code 2 gives odd parity. Code 3 gives a constant 1 and code 4 a constant 0.
- R5: With `fmt_stop2` at 0 there is one stop bit, and with it at 1 there are two. Every bit lasts 16 `baud_tick` pulses, and the next bit is launched on the 16th pulse, where the divided bit clock falls.
- R6: `tx_ready` is 1 exactly when the transmitter is enabled and the holding register is empty. An accepted write drops it. It returns to 1 once the character moves into the shift register.
- R7: A `wr_stb` while `tx_ready` is 0 is ignored. This includes writes while disabled and writes with the holding register full. Such a write leaves the holding register unchanged and produces no frame.
- R8: `tx_empty` is 1, with the line at 1, whenever both the holding register and the shift register are empty. An accepted write clears it.
- R9: A character written while another is being sent follows it directly. Only the one-clock hand-over separates the frames.
- R10: After `dis_cmd`, the frame already in the shift register completes intact. A character left in the holding register is kept and is not sent until the next `en_cmd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| en_cmd | input | 1 | Strobe: enable the transmitter |
| dis_cmd | input | 1 | Strobe: disable the transmitter (wins over en_cmd) |
| wr_stb | input | 1 | Strobe: host writes `wr_data` |
| wr_data | input | 8 | Character to send |
| fmt_bits | input | 2 | Data length code (5 + code bits) |
| fmt_par | input | 3 | Parity mode code |
| fmt_stop2 | input | 1 | 1 selects two stop bits |
| tx_ready | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | Holding and shift registers both empty |
| txd | output | 1 | Serial output line |

## Verification
A bad bit counter or a bad frame image shows up on `txd` within the same frame. The frame checks catch it as a wrong bit, and the timing checks catch it as a frame that ends early or late. A bad holding-register state shows up within a few clocks as a wrong `tx_ready` or `tx_empty`. It can also appear as a missing frame, or as a frame that should not exist, within the next frame time. Each bench check therefore watches the line bit by bit and watches the flags right after every write, enable and disable.

// File: rtl/udt_pkg.sv
// Shared encodings for the double-buffered serial transmitter.
// Assumes: parity codes above PAR_ZERO are treated as "no parity".
package udt_pkg;
    typedef enum logic [2:0] {
        PAR_NONE = 3'd0,
        PAR_EVEN = 3'd1,
        PAR_ODD  = 3'd2,
        PAR_ONE  = 3'd3,
        PAR_ZERO = 3'd4
    } par_mode_e;
endpackage

// File: rtl/udt_bit_timer.sv
// Divides the baud tick by TICKS_PER_BIT while a frame is active and
// pulses bit_end on the last tick of each bit (falling edge of the bit clock).
// Assumes: baud_tick is a one-clock pulse; load restarts the count.
module udt_bit_timer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic load,
    input  logic baud_tick,
    output logic bit_end
);
    localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICKS_PER_BIT - 1);

    logic [TW-1:0] cnt;

    // Count baud ticks within the current bit, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy || load) begin
            cnt <= '0;
        end else if (baud_tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_end = busy && baud_tick && (cnt == LAST);

    // R5
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick && !load) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/udt_hold_reg.sv
// One-character holding register in front of the shift register.
// Accepts a host write only when enabled and empty; frees itself on take.
// Assumes: take is only raised while full is set.
module udt_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enabled,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic              ready,
    output logic [DATA_W-1:0] data
);
    logic accept;

    assign ready  = enabled && !full;
    assign accept = wr_stb && ready;

    // Track whether a character is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (accept) begin
            full <= 1'b1;
        end
    end

    // Capture the host character on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (accept) begin
            data <= wr_data;
        end
    end

    // R7
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !ready) |=> (data == $past(data)));
endmodule

// File: rtl/udt_frame_shifter.sv
// Builds a frame image from a character and the format inputs, then
// shifts it out one bit per bit_end, start bit first, LSB-first data.
// Assumes: DATA_W >= 8 so that codes 0..3 map to 5..8 data bits.
module udt_frame_shifter
    import udt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        fmt_bits,
    input  logic [2:0]        fmt_par,
    input  logic              fmt_stop2,
    input  logic              bit_end,
    output logic              busy,
    output logic              txd
);
    localparam int SREG_W = DATA_W + 3;
    localparam int CNT_W  = $clog2(DATA_W + 5);

    logic [SREG_W-1:0] img;
    logic [SREG_W-1:0] data_x;
    logic [SREG_W-1:0] sreg;
    logic [CNT_W-1:0]  img_len;
    logic [CNT_W-1:0]  left;
    logic              par_bit;
    logic              par_on;
    logic              ones;

    assign data_x = SREG_W'(data);

    // Compose the post-start bit image and the total frame length.
    always_comb begin
        int ndata;
        ndata = 5 + int'(fmt_bits);
        ones  = 1'b0;
        for (int i = 0; i < SREG_W; i++) begin
            if (i < ndata) ones = ones ^ data_x[i];
        end
        par_on = 1'b1;
        case (par_mode_e'(fmt_par))
            PAR_EVEN: par_bit = ones;
            PAR_ODD:  par_bit = ~ones;
            PAR_ONE:  par_bit = 1'b1;
            PAR_ZERO: par_bit = 1'b0;
            default: begin
                par_bit = 1'b1;
                par_on  = 1'b0;
            end
        endcase
        for (int i = 0; i < SREG_W; i++) begin
            if (i < ndata)                 img[i] = data_x[i];
            else if (i == ndata && par_on) img[i] = par_bit;
            else                           img[i] = 1'b1;
        end
        img_len = CNT_W'(2 + ndata + (par_on ? 1 : 0) + (fmt_stop2 ? 1 : 0));
    end

    // Launch the start bit on load, then advance one bit per bit_end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            txd  <= 1'b1;
            sreg <= '1;
            left <= '0;
        end else if (load) begin
            busy <= 1'b1;
            txd  <= 1'b0;
            sreg <= img;
            left <= img_len;
        end else if (bit_end) begin
            if (left == CNT_W'(1)) begin
                busy <= 1'b0;
                txd  <= 1'b1;
            end else begin
                txd  <= sreg[0];
                sreg <= {1'b1, sreg[SREG_W-1:1]};
                left <= left - 1'b1;
            end
        end
    end

    // R8
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);
endmodule

// File: rtl/uart_dbuf_tx.sv
// Double-buffered asynchronous serial transmitter: enable state, holding
// register, bit timer and frame shifter. A disable lets the active frame
// finish and keeps any waiting character for the next enable.
// Assumes: format inputs are stable while a character is being loaded.
module uart_dbuf_tx #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              en_cmd,
    input  logic              dis_cmd,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        fmt_bits,
    input  logic [2:0]        fmt_par,
    input  logic              fmt_stop2,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic              txd
);
    logic              enabled;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              busy;
    logic              load;
    logic              bit_end;

    // Enable state: disable wins over a simultaneous enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled <= 1'b0;
        end else if (dis_cmd) begin
            enabled <= 1'b0;
        end else if (en_cmd) begin
            enabled <= 1'b1;
        end
    end

    assign load     = enabled && hold_full && !busy;
    assign tx_empty = !hold_full && !busy;

    udt_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .enabled (enabled),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (load),
        .full    (hold_full),
        .ready   (tx_ready),
        .data    (hold_data)
    );

    udt_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .load      (load),
        .baud_tick (baud_tick),
        .bit_end   (bit_end)
    );

    udt_frame_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .data      (hold_data),
        .fmt_bits  (fmt_bits),
        .fmt_par   (fmt_par),
        .fmt_stop2 (fmt_stop2),
        .bit_end   (bit_end),
        .busy      (busy),
        .txd       (txd)
    );

    // R6
    ready_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> enabled);
    // R8
    empty_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);
    // R10
    no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !busy) |=> !busy);
endmodule

// File: tb/uart_dbuf_tx_test.sv
`timescale 1ns/1ps
module uart_dbuf_tx_test;
    localparam int BIT_CYC = 32;   // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       en_cmd = 1'b0;
    logic       dis_cmd = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] fmt_bits = 2'd3;
    logic [2:0] fmt_par = 3'd0;
    logic       fmt_stop2 = 1'b0;
    logic       tx_ready;
    logic       tx_empty;
    logic       txd;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int start_cyc = 0;
    bit done = 1'b0;

    uart_dbuf_tx uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .en_cmd(en_cmd),
        .dis_cmd(dis_cmd), .wr_stb(wr_stb), .wr_data(wr_data),
        .fmt_bits(fmt_bits), .fmt_par(fmt_par), .fmt_stop2(fmt_stop2),
        .tx_ready(tx_ready), .tx_empty(tx_empty), .txd(txd)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(negedge clk);
            baud_tick = ~baud_tick;
        end
    end

    // vector: {data, bits code, parity code, two stops}
    localparam logic [13:0] VEC [7] = '{
        {8'h55, 2'd3, 3'd0, 1'b0},
        {8'hA3, 2'd3, 3'd1, 1'b1},
        {8'h1B, 2'd0, 3'd2, 1'b0},
        {8'h6C, 2'd1, 3'd3, 1'b1},
        {8'h7F, 2'd2, 3'd4, 1'b0},
        {8'hC4, 2'd3, 3'd2, 1'b0},
        {8'h0E, 2'd2, 3'd1, 1'b1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected bits after the start bit; returns total frame length in bits.
    function automatic int exp_frame(input logic [7:0] d, input int code, input int par,
                                     input bit st2, output logic [11:0] v);
        int idx = 0;
        int ones = 0;
        int nb = 5 + code;
        v = '1;
        for (int i = 0; i < nb; i++) begin
            v[idx] = d[i];
            ones += int'(d[i]);
            idx++;
        end
        if (par >= 1 && par <= 4) begin
            case (par)
                1: v[idx] = ones[0];
                2: v[idx] = ~ones[0];
                3: v[idx] = 1'b1;
                default: v[idx] = 1'b0;
            endcase
            idx++;
        end
        v[idx] = 1'b1;
        idx++;
        if (st2) begin
            v[idx] = 1'b1;
            idx++;
        end
        return idx + 1;
    endfunction

    task automatic write_char(input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic pulse_en();
        @(negedge clk); en_cmd = 1'b1;
        @(negedge clk); en_cmd = 1'b0;
    endtask

    task automatic pulse_dis();
        @(negedge clk); dis_cmd = 1'b1;
        @(negedge clk); dis_cmd = 1'b0;
    endtask

    // Sample one frame mid-bit and compare with the expected image.
    task automatic receive(input logic [7:0] d, input string tag);
        logic [11:0] v;
        logic [11:0] got;
        int len;
        int wait_cnt = 0;
        len = exp_frame(d, int'(fmt_bits), int'(fmt_par), fmt_stop2, v);
        got = '1;
        @(negedge clk);
        while (txd !== 1'b0 && wait_cnt < 3000) begin
            @(negedge clk);
            wait_cnt++;
        end
        start_cyc = cyc;
        check(wait_cnt < 3000, {tag, " start seen"}, wait_cnt, 0);
        repeat (BIT_CYC / 2) @(negedge clk);
        check(txd === 1'b0, {tag, " R2 start bit"}, int'(txd), 0);
        for (int i = 0; i < len - 1; i++) begin
            repeat (BIT_CYC) @(negedge clk);
            got[i] = txd;
        end
        check(got == v, {tag, " frame bits"}, int'(got), int'(v));
    endtask

    // Watch the line for n cycles and report whether it ever went low.
    task automatic watch_quiet(input int n, input string tag);
        bit low = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) low = 1'b1;
        end
        check(!low, tag, int'(low), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd === 1'b1, "R1 txd idle", int'(txd), 1);
        check(tx_ready === 1'b0, "R1 ready low", int'(tx_ready), 0);
        check(tx_empty === 1'b1, "R1 empty high", int'(tx_empty), 1);

        // R7 write while disabled is ignored
        write_char(8'hFF);
        repeat (3) @(negedge clk);
        check(tx_empty === 1'b1, "R7 disabled write empty", int'(tx_empty), 1);
        pulse_en();
        repeat (2) @(negedge clk);
        check(tx_ready === 1'b1, "R6 ready after enable", int'(tx_ready), 1);
        watch_quiet(100, "R7 no frame from ignored write");

        // Vector table: R2 R3 R4 R5 frames and frame length
        foreach (VEC[k]) begin
            int len;
            logic [11:0] v;
            int dur;
            fmt_bits  = VEC[k][5:4];
            fmt_par   = VEC[k][3:1];
            fmt_stop2 = VEC[k][0];
            len = exp_frame(VEC[k][13:6], int'(fmt_bits), int'(fmt_par), fmt_stop2, v);
            fork
                receive(VEC[k][13:6], $sformatf("R3 R4 vec%0d", k));
                write_char(VEC[k][13:6]);
            join
            while (tx_empty !== 1'b1 && cyc - start_cyc < 1000) @(negedge clk);
            dur = cyc - start_cyc;
            check(dur >= len * BIT_CYC - 3 && dur <= len * BIT_CYC + 3,
                  $sformatf("R5 frame length vec%0d", k), dur, len * BIT_CYC);
        end

        // R9 double buffering with R6 R7 R8 flag behaviour, 8 bits no parity
        fmt_bits = 2'd3; fmt_par = 3'd0; fmt_stop2 = 1'b0;
        fork
            begin
                receive(8'h3C, "R9 first");
                receive(8'hA5, "R9 second");
            end
            begin
                write_char(8'h3C);
                repeat (4) @(negedge clk);
                check(tx_ready === 1'b1, "R6 ready after hand-over", int'(tx_ready), 1);
                check(tx_empty === 1'b0, "R8 empty cleared", int'(tx_empty), 0);
                write_char(8'hA5);
                check(tx_ready === 1'b0, "R6 ready low when held", int'(tx_ready), 0);
                write_char(8'h99);
            end
        join
        watch_quiet(900, "R7 write while full dropped");
        check(tx_empty === 1'b1, "R8 empty after frames", int'(tx_empty), 1);

        // R10 disable finishes active frame, keeps held character
        fork
            receive(8'h81, "R10 active frame");
            begin
                write_char(8'h81);
                repeat (4) @(negedge clk);
                write_char(8'h42);
                repeat (20) @(negedge clk);
                pulse_dis();
                check(tx_ready === 1'b0, "R10 ready low after disable", int'(tx_ready), 0);
            end
        join
        watch_quiet(900, "R10 held char not sent");
        check(tx_empty === 1'b0, "R10 held char kept", int'(tx_empty), 0);
        fork
            receive(8'h42, "R10 held char after enable");
            pulse_en();
        join
        repeat (BIT_CYC) @(negedge clk);
        check(tx_empty === 1'b1, "R8 empty at end", int'(tx_empty), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule